// File: doc/BRIEF.md
# Serial Sampling Converter Read Controller

This block runs single conversions on an external successive-approximation converter that has a three-wire serial port: an active-low select, a serial clock and a data line. A frame starts in one of two ways. The host can pulse a start input, or an optional rate timer can fire. When the frame starts, the controller pulls select low. That edge is the moment the converter samples its input and begins converting. The controller then toggles the serial clock sixteen times and reads the data line on every rising edge, most significant bit first. It raises select again, and a quiet gap must pass before select may fall again.

Each frame has 16 bits. Four zero bits come first, then the result in straight binary, then `12 - DATA_W` trailing bits. The controller keeps only the result field, right-justified, and discards the rest. The result arrives with a one-cycle valid strobe in the same cycle that select returns high. There is no pipeline delay: every result belongs to the frame that just ended. Converter width (8, 10 or 12), serial clock half-period, quiet time and auto-trigger period are parameters. All timing is counted in system clock cycles.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `adc_cs_n_o` is 1, `adc_sclk_o` is 0, `valid_o` is 0 and `busy_o` is 0.
- R2: If `start_i` is high at a clock edge while `busy_o` is low, `adc_cs_n_o` is 0 and `busy_o` is 1 after that edge.
- R3: Each frame has exactly 16 rising edges of `adc_sclk_o`. The serial clock is low whenever select is high.
- R4: The first rising serial clock edge comes HALF_DIV system cycles after select falls. Each high phase and each low phase of the serial clock lasts HALF_DIV cycles.
- R5: The data line is sampled at each rising serial clock edge, giving frame bits 15 down to 0. `result_o` equals frame bits [11 : 12-DATA_W]. The four leading bits and the trailing bits have no effect, whatever their value.
- R6: `valid_o` is high for exactly one cycle per frame, in the first cycle after select returns high.
- R7: Select stays high for at least QUIET_CYC = ceil(QUIET_NS / CLK_NS) cycles between frames. With `start_i` held high, the high gap is exactly QUIET_CYC+1 cycles.
- R8: `busy_o` is high from the edge where select falls until the quiet gap ends. Start requests while busy start no frame.
- R9: While `auto_en_i` is held high, a frame starts AUTO_PERIOD cycles after the enable is first seen, and then every AUTO_PERIOD cycles.
- R10: A start pulse in the same cycle as a timer expiry starts exactly one frame, and the timer's rhythm does not change.
- R11: `result_o` holds its value between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| auto_en_i | input | 1 | Enable the periodic trigger timer |
| adc_sdata_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low select; its falling edge is the sampling instant |
| adc_sclk_o | output | 1 | Serial clock, idles low |
| result_o | output | DATA_W | Last converted value, right-justified |
| valid_o | output | 1 | One-cycle strobe when result_o updates |
| busy_o | output | 1 | Frame or quiet gap in progress |

## Verification
Two triggers can land on the same clock edge: the host start pulse and the rate timer's expiry. The bench enables the timer at a known edge and places a start pulse on exactly the edge where the timer fires. It then checks that select falls only once in that window, that exactly one result is delivered, and that the next timer frame still comes one full period later. It also checks a start request that lands in the last quiet cycle, when the frame has ended but the controller is not yet idle; that request must be dropped.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   localparam int FRAME_BITS = 16;
   localparam int LEAD_BITS  = 4;
   localparam int HALVES     = 2 * FRAME_BITS;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_SETUP,
      SEQ_SHIFT,
      SEQ_QUIET
   } seq_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/adc_rd_rate.sv
module adc_rd_rate #(
   parameter int PERIOD = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);

   generate
      if (PERIOD == 0) begin : g_no_timer
         assign tick_o = 1'b0;
      end else begin : g_timer
         localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!en_i)
               cnt_q <= '0;
            else if (cnt_q == CW'(PERIOD - 1))
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = en_i && (cnt_q == CW'(PERIOD - 1));

         // R9: an expiry is always followed by a restart of the count
         assert_timer_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> (cnt_q == '0));
      end
   endgenerate

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
   import adc_rd_pkg::*;
#(
   parameter int HALF_DIV  = 2,
   parameter int QUIET_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic cs_n_o,
   output logic sclk_o,
   output logic cap_o,
   output logic done_o,
   output logic busy_o
);

   localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int QW     = (QUIET_CYC > 1) ? $clog2(QUIET_CYC) : 1;
   localparam int HALF_W = $clog2(HALVES);

   seq_state_t        state_q;
   logic [DIV_W-1:0]  div_q;
   logic [HALF_W-1:0] half_q;
   logic [QW-1:0]     quiet_q;
   logic              div_end;

   assign div_end = (div_q == DIV_W'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         div_q   <= '0;
         half_q  <= '0;
         quiet_q <= '0;
         cs_n_o  <= 1'b1;
         sclk_o  <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (go_i) begin
                  state_q <= SEQ_SETUP;
                  cs_n_o  <= 1'b0;
                  div_q   <= '0;
               end
            end
            SEQ_SETUP: begin
               if (div_end) begin
                  state_q <= SEQ_SHIFT;
                  sclk_o  <= 1'b1;
                  div_q   <= '0;
                  half_q  <= '0;
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            SEQ_SHIFT: begin
               if (div_end) begin
                  div_q <= '0;
                  if (half_q == HALF_W'(HALVES - 1)) begin
                     state_q <= SEQ_QUIET;
                     cs_n_o  <= 1'b1;
                     quiet_q <= '0;
                  end else begin
                     half_q <= half_q + 1'b1;
                     sclk_o <= ~sclk_o;
                  end
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            SEQ_QUIET: begin
               if (quiet_q == QW'(QUIET_CYC - 1))
                  state_q <= SEQ_IDLE;
               else
                  quiet_q <= quiet_q + 1'b1;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   // capture happens on the edge that raises the serial clock
   assign cap_o  = div_end && ((state_q == SEQ_SETUP) ||
                   ((state_q == SEQ_SHIFT) && !sclk_o && (half_q != HALF_W'(HALVES - 1))));
   assign done_o = div_end && (state_q == SEQ_SHIFT) && (half_q == HALF_W'(HALVES - 1));
   assign busy_o = (state_q != SEQ_IDLE);

   // R3: serial clock parked low outside a frame
   assert_sclk_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o);

   // R2: an accepted request lowers select on the next edge
   assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && go_i) |=> (!cs_n_o && busy_o));

   // R8: during the quiet gap select cannot fall, whatever is requested
   assert_quiet_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cs_n_o) |=> cs_n_o);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter
   import adc_rd_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic              bit_i,
   input  logic              done_i,
   output logic [DATA_W-1:0] result_o,
   output logic              valid_o
);

   localparam int TRAIL_W = FRAME_BITS - LEAD_BITS - DATA_W;
   localparam int TOP_BIT = FRAME_BITS - LEAD_BITS - 1;

   logic [FRAME_BITS-1:0] frame_q;
   logic [DATA_W-1:0]     field;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frame_q <= '0;
      else if (cap_i)
         frame_q <= {frame_q[FRAME_BITS-2:0], bit_i};
   end

   generate
      if (TRAIL_W == 0) begin : g_no_trail
         assign field = frame_q[TOP_BIT:0];
      end else begin : g_trail
         assign field = frame_q[TOP_BIT -: DATA_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= done_i;
         if (done_i)
            result_o <= field;
      end
   end

   // R6: strobe lasts one cycle
   assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R11: result holds between strobes
   assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(result_o));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
   import adc_rd_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int CLK_NS      = 20,
   parameter int HALF_DIV    = 2,
   parameter int QUIET_NS    = 50,
   parameter int AUTO_PERIOD = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              auto_en_i,
   input  logic              adc_sdata_i,
   output logic              adc_cs_n_o,
   output logic              adc_sclk_o,
   output logic [DATA_W-1:0] result_o,
   output logic              valid_o,
   output logic              busy_o
);

   localparam int QUIET_CYC = ceil_div(QUIET_NS, CLK_NS);
   localparam int FRAME_CYC = HALF_DIV * (1 + HALVES) + QUIET_CYC + 1;
   localparam int HC_W      = $clog2(QUIET_CYC + 2);

   generate
      if (!(DATA_W == 8 || DATA_W == 10 || DATA_W == 12)) begin : g_bad_width
         $error("DATA_W must be 8, 10 or 12");
      end
      if (HALF_DIV < 1 || 2 * HALF_DIV * CLK_NS < 50) begin : g_bad_div
         $error("serial clock half period too short");
      end
      if (AUTO_PERIOD != 0 && AUTO_PERIOD < FRAME_CYC) begin : g_bad_period
         $error("AUTO_PERIOD shorter than one frame");
      end
   endgenerate

   logic tick, go, cap, done;

   adc_rd_rate #(.PERIOD(AUTO_PERIOD)) i_rate (
      .clk(clk), .rst_n(rst_n), .en_i(auto_en_i), .tick_o(tick)
   );

   assign go = start_i | tick;

   adc_rd_seq #(.HALF_DIV(HALF_DIV), .QUIET_CYC(QUIET_CYC)) i_seq (
      .clk(clk), .rst_n(rst_n), .go_i(go),
      .cs_n_o(adc_cs_n_o), .sclk_o(adc_sclk_o),
      .cap_o(cap), .done_o(done), .busy_o(busy_o)
   );

   adc_rd_shifter #(.DATA_W(DATA_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .cap_i(cap), .bit_i(adc_sdata_i),
      .done_i(done), .result_o(result_o), .valid_o(valid_o)
   );

   // checker counter: cycles select has been high, saturating
   logic [HC_W-1:0] hi_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_cnt_q <= HC_W'(QUIET_CYC + 1);
      else if (!adc_cs_n_o)
         hi_cnt_q <= '0;
      else if (hi_cnt_q != HC_W'(QUIET_CYC + 1))
         hi_cnt_q <= hi_cnt_q + 1'b1;
   end

   // R7: select high long enough before it falls again
   assert_quiet_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n_o) |-> (hi_cnt_q >= HC_W'(QUIET_CYC)));

   // R6: result delivered as select returns high
   assert_valid_at_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n_o) |-> valid_o);

endmodule

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;

   localparam int DATA_W = 12;
   localparam int HALF   = 2;
   localparam int QUIET  = 3;
   localparam int PER    = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic auto_en = 1'b0;
   logic sdata = 1'b1;
   logic cs_n, sclk, valid, busy;
   logic [DATA_W-1:0] result;

   int tests = 0;
   int fails = 0;
   int dev_idx = -1;
   logic [15:0] dev_word = '0;
   int rises = 0;
   int falls = 0;
   int vcnt  = 0;
   logic [DATA_W-1:0] last_res = '0;

   always #10 clk = ~clk;

   adc_frame_reader #(.DATA_W(DATA_W), .CLK_NS(20), .HALF_DIV(HALF),
                      .QUIET_NS(50), .AUTO_PERIOD(PER)) i_adc_frame_reader (
      .clk(clk), .rst_n(rst_n), .start_i(start), .auto_en_i(auto_en),
      .adc_sdata_i(sdata), .adc_cs_n_o(cs_n), .adc_sclk_o(sclk),
      .result_o(result), .valid_o(valid), .busy_o(busy)
   );

   // converter model: first bit on select fall, next bit after each clock fall
   always @(negedge cs_n) begin
      falls++;
      dev_idx = 15;
      sdata = dev_word[15];
   end
   always @(negedge sclk) begin
      if (!cs_n) begin
         dev_idx--;
         sdata = (dev_idx >= 0) ? dev_word[dev_idx] : 1'b1;
      end
   end
   always @(posedge sclk) rises++;
   always @(posedge clk) if (valid) begin vcnt++; last_res = result; end

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic frame_check(input logic [15:0] w, input int exp_res, input string tag);
      int r0, v0;
      dev_word = w;
      r0 = rises; v0 = vcnt;
      pulse_start();
      wait_idle();
      chk({tag, " R5 result"}, int'(last_res), exp_res);
      chk({tag, " R6 one strobe"}, vcnt - v0, 1);
      chk({tag, " R3 sixteen clocks"}, rises - r0, 16);
   endtask

   task automatic t_reset();
      chk("R1 cs_n", int'(cs_n), 1);
      chk("R1 sclk", int'(sclk), 0);
      chk("R1 valid", int'(valid), 0);
      chk("R1 busy", int'(busy), 0);
   endtask

   task automatic t_accept_and_phases();
      int n, h;
      dev_word = 16'h0123;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R2 cs low", int'(cs_n), 0);
      chk("R2 busy", int'(busy), 1);
      n = 1;
      while (!sclk && n < 50) begin @(negedge clk); if (!sclk) n++; end
      chk("R4 setup cycles", n, HALF);
      h = 0;
      while (sclk && h < 50) begin @(negedge clk); h++; end
      chk("R4 high phase", h, HALF);
      h = 0;
      while (!sclk && h < 50) begin @(negedge clk); h++; end
      chk("R4 low phase", h, HALF);
      wait_idle();
      chk("R5 phases frame", int'(last_res), 12'h123);
   endtask

   task automatic t_ignore_busy();
      int f0, v0;
      logic [DATA_W-1:0] keep;
      dev_word = 16'h0456;
      f0 = falls; v0 = vcnt;
      pulse_start();
      repeat (10) @(negedge clk);
      pulse_start();
      repeat (30) @(negedge clk);
      pulse_start();
      while (!valid) @(negedge clk);
      chk("R6 valid with cs high", int'(cs_n), 1);
      chk("R8 busy in quiet", int'(busy), 1);
      // request in the last quiet cycle
      repeat (QUIET - 1) @(negedge clk);
      chk("R8 still busy", int'(busy), 1);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      keep = result;
      repeat (5) @(negedge clk);
      chk("R8 no new frame", falls - f0, 1);
      chk("R8 cs stays high", int'(cs_n), 1);
      chk("R8 one result", vcnt - v0, 1);
      chk("R11 result held", int'(result), int'(keep));
   endtask

   task automatic t_back_to_back();
      int gap, f0;
      dev_word = 16'h0789;
      f0 = falls;
      @(negedge clk) start = 1'b1;
      while (!(valid)) @(negedge clk);
      gap = 1;
      while (cs_n && gap < 50) begin @(negedge clk); if (cs_n) gap++; end
      chk("R7 gap", gap, QUIET + 1);
      @(negedge clk) start = 1'b0;
      wait_idle();
      chk("R7 two frames", falls - f0, 2);
      chk("R7 second result", int'(last_res), 12'h789);
   endtask

   task automatic t_auto();
      int k, f0;
      dev_word = 16'h0ACE;
      @(negedge clk) auto_en = 1'b1;
      k = 0;
      while (cs_n && k < 300) begin @(negedge clk); k++; end
      chk("R9 first period", k, PER);
      while (!cs_n) @(negedge clk);
      k = 0;
      f0 = falls;
      while (falls == f0 && k < 300) begin @(negedge clk); k++; end
      chk("R9 repeat period", k + 2 * HALF * 16 + HALF, PER);
      @(negedge clk) auto_en = 1'b0;
      wait_idle();
      chk("R9 result", int'(last_res), 12'hACE);
   endtask

   task automatic t_coincide();
      int f0, v0, k;
      dev_word = 16'h0321;
      f0 = falls; v0 = vcnt;
      @(negedge clk) auto_en = 1'b1;
      repeat (PER - 1) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R10 frame started", int'(cs_n), 0);
      repeat (PER - 10) @(negedge clk);
      chk("R10 single frame", falls - f0, 1);
      chk("R10 single result", vcnt - v0, 1);
      k = PER - 10;
      while (falls == f0 + 1 && k < 300) begin @(negedge clk); k++; end
      chk("R10 rhythm kept", k, PER);
      auto_en = 1'b0;
      wait_idle();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      frame_check(16'h0ABC, 12'hABC, "plain");
      frame_check(16'hF5A5, 12'h5A5, "padding ones");
      frame_check(16'h0FFF, 12'hFFF, "all ones");
      frame_check(16'hF000, 12'h000, "zero");
      t_accept_and_phases();
      t_ignore_busy();
      t_back_to_back();
      t_auto();
      t_coincide();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule